// File: doc/BRIEF.md
# Two-Channel Serial-Bus Wiper Register

This block is a two-wire serial-bus slave that holds two 8-bit wiper position codes and two general-purpose logic outputs. SCL and SDA are sampled against the system clock through a two-flop synchronizer. The block drives SDA only through an open-drain enable, `sda_oe`: 1 pulls the line low and 0 releases it. The 7-bit device address is the fixed pattern `01011` followed by two strap pins, so four of these blocks can share one bus.

A write transfer carries the address byte, one instruction byte and one or more data bytes. The instruction picks the channel, can force that channel to midscale (`8'h80`), sets or clears that channel's soft shutdown flag, and loads the two logic outputs. The instruction stays latched for the rest of the transfer, so each further data byte updates the same channel. A read transfer returns the wiper of the channel named by the most recent instruction, and repeats it for as long as the master acknowledges. Each channel reports an effective shutdown flag, which is the soft flag ORed with an active-low shutdown pin.

The controller `dwi_link` is a state machine with nine states:
- `ST_IDLE`: waits for a start.
- `ST_ADDR`, `ST_INSTR`, `ST_DATA`: receive a byte.
- `ST_ADDR_ACK`, `ST_INSTR_ACK`, `ST_DATA_ACK`: drive the acknowledge.
- `ST_TX`: shifts a read byte out.
- `ST_TX_ACK`: samples the master's acknowledge.

Transitions:
- From any state, a start goes to `ST_ADDR` and a stop goes to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on an address match, or to `ST_IDLE` on a miss.
- `ST_ADDR_ACK` goes to `ST_TX` for a read or to `ST_INSTR` for a write.
- `ST_INSTR` goes to `ST_INSTR_ACK`, then to `ST_DATA`.
- `ST_DATA` goes to `ST_DATA_ACK`, and back to `ST_DATA`.
- `ST_TX` goes to `ST_TX_ACK` after eight bits. From there an acknowledge returns to `ST_TX` and a no-acknowledge goes to `ST_IDLE`.

Top module: `dual_wiper_i2c`

## Requirements
- R1: After reset, both wipers read `8'h80`, both soft shutdown flags and both logic outputs are 0, and `sda_oe` is 0.
- R2: An address byte whose upper seven bits equal `{5'b01011, addr_pin[1], addr_pin[0]}` is acknowledged (SDA low on the ninth clock). Any other address gets no acknowledge, and the rest of that transfer has no effect on any output.
- R3: In a write, instruction bit 7 selects the channel (0 = `wiper1`, 1 = `wiper2`). The data byte that follows loads that wiper, leaves the other one unchanged, and is acknowledged.
- R4: Every further data byte in the same write transfer is acknowledged and loads the channel chosen by that transfer's instruction.
- R5: Instruction bit 6 = 1 sets the selected wiper to `8'h80` when the instruction byte completes. Data bytes later in that transfer leave it at `8'h80`.
- R6: Instruction bit 5 sets the selected channel's soft shutdown flag to the bit's value and does not alter any wiper code. The unselected channel's flag is unchanged.
- R7: While `shdn_n` is 0, `off1` and `off2` are both 1. While it is 1, each follows its soft flag.
- R8: Every accepted instruction copies bit 4 to `gpo[0]` and bit 3 to `gpo[1]`. Bits 2:0 have no effect on any output.
- R9: A read returns the wiper of the most recently selected channel, MSB first. The byte repeats while the master acknowledges. After a no-acknowledge, `sda_oe` is 0.
- R10: A stop ends a transfer, and a new transfer needs a start and an address. A repeated start begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| addr_pin | input | 2 | Low two bits of the device address |
| shdn_n | input | 1 | Active-low shutdown of both channels |
| wiper1 | output | 8 | Channel 1 wiper code |
| wiper2 | output | 8 | Channel 2 wiper code |
| off1 | output | 1 | Channel 1 effective shutdown |
| off2 | output | 1 | Channel 2 effective shutdown |
| gpo | output | 2 | Logic outputs from instruction bits 4 and 3 |

## Verification
Address decoding is swept over all sixteen pairings of strap-pin value and transmitted low address bits. This separates the single matching address from its three near misses, and confirms that a missed transfer's instruction and data are discarded. Long repeated writes on each channel, with arithmetic data sequences, show whether the latched channel survives across bytes and whether the other channel stays untouched. A sweep over all 32 values of instruction bits 4:0 separates the logic-output bits from the ignored low bits. Midscale, shutdown, pin shutdown, repeated reads with an acknowledge and a final no-acknowledge, a repeated start and a stop each get a dedicated transfer.

// File: rtl/dwi_pkg.sv
package dwi_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INSTR,
        ST_INSTR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_TX,
        ST_TX_ACK
    } dwi_state_e;
endpackage

// File: rtl/dwi_sync.sv
module dwi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] ff;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ff      <= '1;
                prev[g] <= 1'b1;
            end else begin
                ff      <= {ff[STAGES-2:0], raw[g]};
                prev[g] <= ff[STAGES-1];
            end
        end
        assign synced[g] = ff[STAGES-1];
    end

    assign sda_s     = synced[1];
    assign scl_rise  = synced[0] & ~prev[0];
    assign scl_fall  = ~synced[0] & prev[0];
    assign start_det = synced[0] & prev[0] & prev[1] & ~synced[1];
    assign stop_det  = synced[0] & prev[0] & ~prev[1] & synced[1];
endmodule

// File: rtl/dwi_link.sv
module dwi_link
    import dwi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_s,
    input  logic [6:0]        dev_addr,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sda_oe,
    output logic              instr_we,
    output logic              data_we,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    dwi_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] sh_q;
    logic              mack_q;
    logic              byte_done;

    assign byte_done = scl_fall && (cnt_q == FULL);

    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_ADDR:      if (byte_done)
                                  state_d = (sh_q[7:1] == dev_addr) ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:  if (scl_fall) state_d = sh_q[0] ? ST_TX : ST_INSTR;
                ST_INSTR:     if (byte_done) state_d = ST_INSTR_ACK;
                ST_INSTR_ACK: if (scl_fall) state_d = ST_DATA;
                ST_DATA:      if (byte_done) state_d = ST_DATA_ACK;
                ST_DATA_ACK:  if (scl_fall) state_d = ST_DATA;
                ST_TX:        if (scl_fall && cnt_q == LAST) state_d = ST_TX_ACK;
                ST_TX_ACK:    if (scl_fall) state_d = mack_q ? ST_TX : ST_IDLE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sh_q   <= '0;
            mack_q <= 1'b0;
        end else if (start_det || stop_det) begin
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_ADDR, ST_INSTR, ST_DATA: begin
                    if (scl_rise) begin
                        sh_q  <= {sh_q[BYTE_W-2:0], sda_s};
                        cnt_q <= cnt_q + 1'b1;
                    end else if (byte_done) begin
                        cnt_q <= '0;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall && sh_q[0]) begin
                        sh_q  <= rd_byte;
                        cnt_q <= '0;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) mack_q <= ~sda_s;
                    if (scl_fall) begin
                        sh_q  <= rd_byte;
                        cnt_q <= '0;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    always_comb begin
        sda_oe   = (state_q == ST_ADDR_ACK) || (state_q == ST_INSTR_ACK) ||
                   (state_q == ST_DATA_ACK) || ((state_q == ST_TX) && !sh_q[BYTE_W-1]);
        instr_we = (state_q == ST_INSTR) && byte_done;
        data_we  = (state_q == ST_DATA) && byte_done;
        rx_byte  = sh_q;
    end
endmodule

// File: rtl/dwi_bank.sv
module dwi_bank
    import dwi_pkg::*;
#(
    parameter logic [BYTE_W-1:0] MIDSCALE = 8'h80
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        instr_we,
    input  logic                        data_we,
    input  logic [BYTE_W-1:0]           rx_byte,
    input  logic                        shdn_n,
    output logic [1:0][BYTE_W-1:0]      wiper,
    output logic [1:0]                  off,
    output logic [1:0]                  gpo,
    output logic [BYTE_W-1:0]           rd_byte
);
    localparam int CH = 2;

    logic sel_q;
    logic rs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            rs_q  <= 1'b0;
            gpo   <= '0;
        end else if (instr_we) begin
            sel_q <= rx_byte[7];
            rs_q  <= rx_byte[6];
            gpo   <= {rx_byte[3], rx_byte[4]};
        end
    end

    for (genvar c = 0; c < CH; c++) begin : g_ch
        logic sd_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wiper[c] <= MIDSCALE;
                sd_q     <= 1'b0;
            end else if (instr_we && (rx_byte[7] == 1'(c))) begin
                if (rx_byte[6]) wiper[c] <= MIDSCALE;
                sd_q <= rx_byte[5];
            end else if (data_we && (sel_q == 1'(c)) && !rs_q) begin
                wiper[c] <= rx_byte;
            end
        end
        assign off[c] = sd_q | ~shdn_n;
    end

    assign rd_byte = wiper[sel_q];
endmodule

// File: rtl/dual_wiper_i2c.sv
module dual_wiper_i2c #(
    parameter int         SYNC_STAGES = 2,
    parameter logic [4:0] ADDR_HI     = 5'b01011
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [1:0] addr_pin,
    input  logic       shdn_n,
    output logic [7:0] wiper1,
    output logic [7:0] wiper2,
    output logic       off1,
    output logic       off2,
    output logic [1:0] gpo
);
    logic                 sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic                 instr_we, data_we;
    logic [7:0]           rx_byte, rd_byte;
    logic [1:0][7:0]      wiper;
    logic [1:0]           off;

    dwi_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    dwi_link link_i (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
        .dev_addr({ADDR_HI, addr_pin}), .rd_byte(rd_byte), .sda_oe(sda_oe),
        .instr_we(instr_we), .data_we(data_we), .rx_byte(rx_byte)
    );

    dwi_bank bank_i (
        .clk(clk), .rst_n(rst_n), .instr_we(instr_we), .data_we(data_we),
        .rx_byte(rx_byte), .shdn_n(shdn_n), .wiper(wiper), .off(off),
        .gpo(gpo), .rd_byte(rd_byte)
    );

    assign wiper1 = wiper[0];
    assign wiper2 = wiper[1];
    assign off1   = off[0];
    assign off2   = off[1];
endmodule

// File: rtl/dual_wiper_i2c_chk.sv
module dual_wiper_i2c_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       shdn_n,
    input logic [7:0] wiper1,
    input logic [7:0] wiper2,
    input logic       off1,
    input logic       off2,
    input logic [1:0] gpo
);
    // R3
    wiper1_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wiper1) |-> !scl_i);

    // R4
    wiper2_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wiper2) |-> !scl_i);

    // R8
    gpo_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gpo) |-> !scl_i);

    // R9
    sda_drive_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R7
    pin_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |-> (off1 && off2));
endmodule

bind dual_wiper_i2c dual_wiper_i2c_chk chk_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .shdn_n(shdn_n),
    .wiper1(wiper1), .wiper2(wiper2), .off1(off1), .off2(off2), .gpo(gpo)
);

// File: tb/dual_wiper_i2c_tb_top.sv
module dual_wiper_i2c_tb_top;
    localparam int Q = 6;
    localparam logic [4:0] HI = 5'b01011;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n, scl_m, sda_m, shdn_n, sda_oe, off1, off2;
    logic [1:0] pins, gpo;
    logic [7:0] wiper1, wiper2;
    wire        sda_line = sda_m & ~sda_oe;

    dual_wiper_i2c dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .addr_pin(pins), .shdn_n(shdn_n), .wiper1(wiper1), .wiper2(wiper2),
        .off1(off1), .off2(off2), .gpo(gpo)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [7:0] m_w [2];
    logic       m_sd [2];
    logic       m_sel, m_rs;
    logic [1:0] m_gpo;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); sda_m = 1'b0; hq(); scl_m = 1'b0; hq();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; hq(); scl_m = 1'b1; hq(); sda_m = 1'b1; hq(); hq();
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hq(); scl_m = 1'b1; hq(); hq(); scl_m = 1'b0; hq();
        end
        sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); ack = ~sda_line; hq(); scl_m = 1'b0; hq();
    endtask

    task automatic rd_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hq(); scl_m = 1'b1; hq(); b[i] = sda_line; hq(); scl_m = 1'b0;
        end
        hq(); sda_m = ~mack; hq(); scl_m = 1'b1; hq(); hq(); scl_m = 1'b0; hq();
        sda_m = 1'b1;
    endtask

    task automatic apply_instr(input logic [7:0] ins);
        m_sel = ins[7];
        m_rs  = ins[6];
        if (ins[6]) m_w[ins[7]] = 8'h80;
        m_sd[ins[7]] = ins[5];
        m_gpo = {ins[3], ins[4]};
    endtask

    task automatic apply_data(input logic [7:0] d);
        if (!m_rs) m_w[m_sel] = d;
    endtask

    task automatic check_state(input string req);
        chk(wiper1 == m_w[0], {req, " wiper1"}, wiper1, m_w[0]);
        chk(wiper2 == m_w[1], {req, " wiper2"}, wiper2, m_w[1]);
        chk(off1 == (m_sd[0] | ~shdn_n), {req, " off1"}, off1, m_sd[0] | ~shdn_n);
        chk(off2 == (m_sd[1] | ~shdn_n), {req, " off2"}, off2, m_sd[1] | ~shdn_n);
        chk(gpo == m_gpo, {req, " gpo"}, gpo, m_gpo);
    endtask

    function automatic logic [7:0] addr_w(input logic [1:0] lo, input bit rd);
        return {HI, lo, rd};
    endfunction

    // write transfer: instruction then nd data bytes d0, d0+step, ...
    task automatic write_seq(input logic [7:0] ins, input int nd, input logic [7:0] d0,
                             input logic [7:0] step, input string req);
        bit ack;
        logic [7:0] d;
        i2c_start();
        wr_byte(addr_w(pins, 1'b0), ack);
        chk(ack, {req, " addr ack"}, ack, 1);
        wr_byte(ins, ack);
        apply_instr(ins);
        chk(ack, {req, " instr ack"}, ack, 1);
        check_state({req, " after instr"});
        d = d0;
        for (int k = 0; k < nd; k++) begin
            wr_byte(d, ack);
            apply_data(d);
            chk(ack, {req, " data ack"}, ack, 1);
            check_state({req, " after data"});
            d = d + step;
        end
        i2c_stop();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        bit ack;
        logic [7:0] rb;
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; shdn_n = 1'b1; pins = 2'b10;
        m_w[0] = 8'h80; m_w[1] = 8'h80; m_sd[0] = 1'b0; m_sd[1] = 1'b0;
        m_sel = 1'b0; m_rs = 1'b0; m_gpo = 2'b00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        check_state("R1");
        chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);

        // R3 / R4 repeated writes on each channel
        write_seq(8'h80, 16, 8'h05, 8'd37, "R4 ch2");
        write_seq(8'h00, 16, 8'hF0, 8'd23, "R3 ch1");

        // R2 address sweep over strap pins and sent low bits
        for (int p = 0; p < 4; p++) begin
            pins = 2'(p);
            hq();
            for (int t = 0; t < 4; t++) begin
                i2c_start();
                wr_byte(addr_w(2'(t), 1'b0), ack);
                chk(ack == (p == t), "R2 address ack", ack, p == t);
                if (p == t) begin
                    wr_byte(8'h00, ack);
                    apply_instr(8'h00);
                    wr_byte(8'(8'h10 + p * 4 + t), ack);
                    apply_data(8'(8'h10 + p * 4 + t));
                end else begin
                    wr_byte(8'hE8, ack);
                    chk(!ack, "R2 ignored instr ack", ack, 0);
                    wr_byte(8'h00, ack);
                    chk(!ack, "R2 ignored data ack", ack, 0);
                end
                i2c_stop();
                check_state("R2");
            end
        end
        pins = 2'b10;
        hq();

        // R5 midscale forced and held
        write_seq(8'hC0, 3, 8'h55, 8'd1, "R5 ch2");
        chk(wiper2 == 8'h80, "R5 midscale", wiper2, 8'h80);
        write_seq(8'h40, 1, 8'h11, 8'd0, "R5 ch1");

        // R6 soft shutdown keeps code, clearing restores
        write_seq(8'h00, 1, 8'h3C, 8'd0, "R6 load");
        write_seq(8'h20, 0, 8'h00, 8'd0, "R6 set ch1");
        chk(off1 && !off2 && wiper1 == 8'h3C, "R6 ch1 off", {off1, off2, wiper1}, {2'b10, 8'h3C});
        write_seq(8'hA0, 0, 8'h00, 8'd0, "R6 set ch2");
        write_seq(8'h00, 0, 8'h00, 8'd0, "R6 clear ch1");
        chk(!off1 && wiper1 == 8'h3C, "R6 restored", {off1, wiper1}, {1'b0, 8'h3C});
        write_seq(8'h80, 0, 8'h00, 8'd0, "R6 clear ch2");

        // R7 pin shutdown
        shdn_n = 1'b0;
        hq();
        check_state("R7 pin low");
        chk(off1 && off2, "R7 both off", {off1, off2}, 2'b11);
        shdn_n = 1'b1;
        hq();
        check_state("R7 pin high");

        // R8 logic outputs and ignored low bits
        for (int v = 0; v < 32; v++) begin
            write_seq(8'(v), 0, 8'h00, 8'd0, "R8");
        end

        // R9 read with repeats then a no-acknowledge
        write_seq(8'h80, 1, 8'h5A, 8'd0, "R9 setup");
        i2c_start();
        wr_byte(addr_w(pins, 1'b1), ack);
        chk(ack, "R9 read addr ack", ack, 1);
        rd_byte(1'b1, rb);
        chk(rb == m_w[1], "R9 read byte 1", rb, m_w[1]);
        rd_byte(1'b1, rb);
        chk(rb == m_w[1], "R9 read byte 2", rb, m_w[1]);
        rd_byte(1'b0, rb);
        chk(rb == m_w[1], "R9 read byte 3", rb, m_w[1]);
        chk(sda_oe == 1'b0, "R9 released after nack", sda_oe, 0);
        i2c_stop();

        // R10 repeated start switches to a read of the new selection
        i2c_start();
        wr_byte(addr_w(pins, 1'b0), ack);
        wr_byte(8'h00, ack);
        apply_instr(8'h00);
        i2c_start();
        wr_byte(addr_w(pins, 1'b1), ack);
        chk(ack, "R10 repeated start addr ack", ack, 1);
        rd_byte(1'b0, rb);
        chk(rb == m_w[0], "R10 read after repeated start", rb, m_w[0]);
        i2c_stop();

        // R10 stop ends transfer; next byte is decoded as an address
        i2c_start();
        wr_byte(addr_w(pins, 1'b0), ack);
        wr_byte(8'h80, ack);
        apply_instr(8'h80);
        i2c_stop();
        i2c_start();
        wr_byte(8'h77, ack);
        chk(!ack, "R10 byte after stop is an address", ack, 0);
        wr_byte(8'h77, ack);
        chk(!ack, "R10 no data ack", ack, 0);
        i2c_stop();
        check_state("R10");

        finish_run();
    end
endmodule